// File: doc/BRIEF.md
# UART Channel FIFO Pair with DMA Request Pins

This block holds the transmit and receive byte FIFOs of one UART channel and drives two active-low request pins, `rxReadyN` and `txReadyN`, which an external DMA controller watches to decide when to move data. The serializer pops from the transmit FIFO and pushes into the receive FIFO. The host side does the opposite. A receive timeout pulse comes from the receive framing logic outside this block.

One mode input selects how the pins behave. In single-transfer mode each pin follows FIFO occupancy directly. In block (DMA) mode the receive pin asserts only once a trigger level or timeout is reached and stays asserted until the FIFO drains. The transmit pin then means "transmit FIFO full".

FIFO capacity is 32 bytes unless any of four level/threshold configuration bytes is nonzero. In that case both FIFOs hold 128 bytes.

All outputs are registered. After a clock edge the counts, pins, pop data and overrun pulses all describe the state that edge produced.

Top module: `chan_fifo_ready`

## Requirements
- R1: While `rstN` is low both counts are 0, `rxReadyN` is 1, `txReadyN` is 0, both overrun outputs are 0 and both pop data outputs are 0.
- R2: Each FIFO returns bytes in push order. A pop accepted at an edge puts the popped byte on the pop data output after that edge, and the count changes at the same edge. A push and a pop in one cycle are both accepted when the FIFO is neither full nor empty.
- R3: With all four configuration bytes zero, a FIFO is full at 32 bytes. A push into a full FIFO is dropped and pulses that FIFO's overrun output high for the one cycle after that edge.
- R4: When any of `txLevelCfg`, `rxLevelCfg`, `flowHiCfg` or `flowLoCfg` is nonzero, both FIFOs are full at 128 bytes, with the same drop and overrun rule.
- R5: With `dmaMode` = 0, `rxReadyN` is 0 exactly when the receive count after the edge is nonzero.
- R6: With `dmaMode` = 1, `rxReadyN` goes to 1 when the receive count becomes 0. It goes to 0 when the count is nonzero and either reaches `rxTrigLevel` or `rxTimeout` is high. Otherwise it holds its value. A trigger level of 0 acts as 1.
- R7: With `dmaMode` = 0, `txReadyN` is 1 exactly when the transmit count after the edge is nonzero.
- R8: With `dmaMode` = 1, `txReadyN` is 1 exactly when the transmit count after the edge has reached the current capacity.
- R9: A pop from an empty FIFO leaves its count and its pop data output unchanged.
- R10: A change of `dmaMode` takes effect on both pins at the next clock edge, evaluated from the occupancy after that edge.
- R11: `rxTimeout` has no effect when the receive FIFO is empty after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaMode | input | 1 | 1 selects block (DMA) pin behaviour |
| txLevelCfg | input | 8 | Transmit level configuration byte (nonzero selects extended depth) |
| rxLevelCfg | input | 8 | Receive level configuration byte (nonzero selects extended depth) |
| flowHiCfg | input | 8 | Flow upper threshold byte (nonzero selects extended depth) |
| flowLoCfg | input | 8 | Flow lower threshold byte (nonzero selects extended depth) |
| rxTrigLevel | input | CNT_W | Receive trigger level in bytes |
| txPush | input | 1 | Host write strobe into transmit FIFO |
| txPushData | input | DATA_W | Host write byte |
| txPop | input | 1 | Serializer read strobe from transmit FIFO |
| txPopData | output | DATA_W | Last byte read from transmit FIFO |
| rxPush | input | 1 | Deserializer write strobe into receive FIFO |
| rxPushData | input | DATA_W | Received byte |
| rxPop | input | 1 | Host read strobe from receive FIFO |
| rxPopData | output | DATA_W | Last byte read from receive FIFO |
| rxTimeout | input | 1 | One-cycle receive timeout pulse |
| txCount | output | CNT_W | Transmit FIFO occupancy |
| rxCount | output | CNT_W | Receive FIFO occupancy |
| txReadyN | output | 1 | Active-low transmit request pin |
| rxReadyN | output | 1 | Active-low receive request pin |
| txOverrun | output | 1 | One-cycle pulse after a dropped transmit push |
| rxOverrun | output | 1 | One-cycle pulse after a dropped receive push |

## Verification
The bench uses the default parameters: 8-bit data, 128-byte storage and 32-byte normal depth. Both full points are therefore reached in a few hundred cycles, as are the drop of the byte after them and the change of capacity while bytes are stored. The receive trigger level is driven with small values and with 0. This covers the hysteretic hold of the receive pin between the trigger and the drain, and the degenerate trigger case. A long phase of random traffic toggles the mode and the configuration bytes during operation, which covers mode changes against every occupancy pattern.

// File: rtl/chan_fifo_pkg.sv
package chan_fifo_pkg;
  // Accepted FIFO operations for one clock, issued by control to datapath.
  typedef struct packed {
    logic txWr;
    logic txRd;
    logic rxWr;
    logic rxRd;
  } fifoStrobe_t;
endpackage

// File: rtl/chan_fifo_lane.sv
module chan_fifo_lane #(
  parameter int DATA_W    = 8,
  parameter int DEPTH_MAX = 128,
  parameter int CNT_W     = $clog2(DEPTH_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count
);
  localparam int PTR_W = (DEPTH_MAX > 1) ? $clog2(DEPTH_MAX) : 1;

  logic [DATA_W-1:0] store [DEPTH_MAX];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH_MAX - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wrEn) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else begin
      if (wrEn) wrPtr <= bump(wrPtr);
      if (rdEn) begin
        rdPtr  <= bump(rdPtr);
        rdData <= store[rdPtr];
      end
      count <= count + CNT_W'(wrEn) - CNT_W'(rdEn);
    end
  end
endmodule

// File: rtl/chan_fifo_dp.sv
module chan_fifo_dp
  import chan_fifo_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH_MAX = 128,
  parameter int CNT_W     = $clog2(DEPTH_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] txWrData,
  input  logic [DATA_W-1:0] rxWrData,
  output logic [DATA_W-1:0] txRdData,
  output logic [DATA_W-1:0] rxRdData,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);
  chan_fifo_lane #(.DATA_W(DATA_W), .DEPTH_MAX(DEPTH_MAX), .CNT_W(CNT_W)) u_txLane (
    .clk(clk), .rstN(rstN), .wrEn(strobe.txWr), .rdEn(strobe.txRd),
    .wrData(txWrData), .rdData(txRdData), .count(txCount)
  );

  chan_fifo_lane #(.DATA_W(DATA_W), .DEPTH_MAX(DEPTH_MAX), .CNT_W(CNT_W)) u_rxLane (
    .clk(clk), .rstN(rstN), .wrEn(strobe.rxWr), .rdEn(strobe.rxRd),
    .wrData(rxWrData), .rdData(rxRdData), .count(rxCount)
  );
endmodule

// File: rtl/chan_fifo_ctl.sv
module chan_fifo_ctl
  import chan_fifo_pkg::*;
#(
  parameter int DEPTH_MAX  = 128,
  parameter int DEPTH_NORM = 32,
  parameter int CFG_W      = 8,
  parameter int CNT_W      = $clog2(DEPTH_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dmaMode,
  input  logic [CFG_W-1:0] txLevelCfg,
  input  logic [CFG_W-1:0] rxLevelCfg,
  input  logic [CFG_W-1:0] flowHiCfg,
  input  logic [CFG_W-1:0] flowLoCfg,
  input  logic [CNT_W-1:0] rxTrigLevel,
  input  logic             txPush,
  input  logic             txPop,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             rxTimeout,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  output fifoStrobe_t      strobe,
  output logic             txReadyN,
  output logic             rxReadyN,
  output logic             txOverrun,
  output logic             rxOverrun
);
  localparam logic [CNT_W-1:0] CAP_EXT  = CNT_W'(DEPTH_MAX);
  localparam logic [CNT_W-1:0] CAP_NORM = CNT_W'(DEPTH_NORM);

  logic             extMode;
  logic [CNT_W-1:0] capNow;
  logic             txFull, rxFull, txEmpty, rxEmpty;
  logic [CNT_W-1:0] txNext, rxNext;
  logic             txPinNxt, rxPinNxt;

  assign extMode = (|txLevelCfg) | (|rxLevelCfg) | (|flowHiCfg) | (|flowLoCfg);
  assign capNow  = extMode ? CAP_EXT : CAP_NORM;

  assign txFull  = (txCount >= capNow);
  assign rxFull  = (rxCount >= capNow);
  assign txEmpty = (txCount == '0);
  assign rxEmpty = (rxCount == '0);

  always_comb begin
    strobe.txWr = txPush & ~txFull;
    strobe.txRd = txPop  & ~txEmpty;
    strobe.rxWr = rxPush & ~rxFull;
    strobe.rxRd = rxPop  & ~rxEmpty;
  end

  assign txNext = txCount + CNT_W'(strobe.txWr) - CNT_W'(strobe.txRd);
  assign rxNext = rxCount + CNT_W'(strobe.rxWr) - CNT_W'(strobe.rxRd);

  always_comb begin
    txPinNxt = dmaMode ? (txNext >= capNow) : (txNext != '0);
    rxPinNxt = rxReadyN;
    if (!dmaMode)                                  rxPinNxt = (rxNext == '0);
    else if (rxNext == '0)                         rxPinNxt = 1'b1;
    else if ((rxNext >= rxTrigLevel) || rxTimeout) rxPinNxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReadyN  <= 1'b0;
      rxReadyN  <= 1'b1;
      txOverrun <= 1'b0;
      rxOverrun <= 1'b0;
    end else begin
      txReadyN  <= txPinNxt;
      rxReadyN  <= rxPinNxt;
      txOverrun <= txPush & txFull;
      rxOverrun <= rxPush & rxFull;
    end
  end
endmodule

// File: rtl/chan_fifo_ready.sv
module chan_fifo_ready
  import chan_fifo_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEPTH_MAX  = 128,
  parameter int DEPTH_NORM = 32,
  parameter int CNT_W      = $clog2(DEPTH_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaMode,
  input  logic [7:0]        txLevelCfg,
  input  logic [7:0]        rxLevelCfg,
  input  logic [7:0]        flowHiCfg,
  input  logic [7:0]        flowLoCfg,
  input  logic [CNT_W-1:0]  rxTrigLevel,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txPushData,
  input  logic              txPop,
  output logic [DATA_W-1:0] txPopData,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxPopData,
  input  logic              rxTimeout,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic              txReadyN,
  output logic              rxReadyN,
  output logic              txOverrun,
  output logic              rxOverrun
);
  fifoStrobe_t strobe;

  chan_fifo_ctl #(
    .DEPTH_MAX(DEPTH_MAX), .DEPTH_NORM(DEPTH_NORM), .CFG_W(8), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .dmaMode(dmaMode),
    .txLevelCfg(txLevelCfg), .rxLevelCfg(rxLevelCfg),
    .flowHiCfg(flowHiCfg), .flowLoCfg(flowLoCfg),
    .rxTrigLevel(rxTrigLevel),
    .txPush(txPush), .txPop(txPop), .rxPush(rxPush), .rxPop(rxPop),
    .rxTimeout(rxTimeout), .txCount(txCount), .rxCount(rxCount),
    .strobe(strobe), .txReadyN(txReadyN), .rxReadyN(rxReadyN),
    .txOverrun(txOverrun), .rxOverrun(rxOverrun)
  );

  chan_fifo_dp #(.DATA_W(DATA_W), .DEPTH_MAX(DEPTH_MAX), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txWrData(txPushData), .rxWrData(rxPushData),
    .txRdData(txPopData), .rxRdData(rxPopData),
    .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: rtl/chan_fifo_ready_chk.sv
module chan_fifo_ready_chk #(
  parameter int DATA_W     = 8,
  parameter int DEPTH_MAX  = 128,
  parameter int DEPTH_NORM = 32,
  parameter int CNT_W      = $clog2(DEPTH_MAX + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              dmaMode,
  input logic [7:0]        txLevelCfg,
  input logic [7:0]        rxLevelCfg,
  input logic [7:0]        flowHiCfg,
  input logic [7:0]        flowLoCfg,
  input logic              txPush,
  input logic              rxPop,
  input logic [DATA_W-1:0] rxPopData,
  input logic [CNT_W-1:0]  txCount,
  input logic [CNT_W-1:0]  rxCount,
  input logic              txReadyN,
  input logic              rxReadyN,
  input logic              txOverrun
);
  logic       wide;
  logic [31:0] capChk;
  assign wide   = (txLevelCfg != 8'd0) || (rxLevelCfg != 8'd0) ||
                  (flowHiCfg != 8'd0) || (flowLoCfg != 8'd0);
  assign capChk = wide ? DEPTH_MAX : DEPTH_NORM;

  // R5
  rx_level_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(dmaMode) |-> (rxReadyN == (rxCount == '0)));

  // R7
  tx_level_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(dmaMode) |-> (txReadyN == (txCount != '0)));

  // R8
  tx_full_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(dmaMode) |-> (txReadyN == (32'(txCount) >= $past(capChk))));

  // R6
  rx_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxReadyN) && $past(dmaMode)) |-> (rxCount == '0));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(txPush) && (32'($past(txCount)) >= $past(capChk))) |->
      (txOverrun && (txCount <= $past(txCount))));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxPop) && ($past(rxCount) == '0)) |-> $stable(rxPopData));
endmodule

bind chan_fifo_ready chan_fifo_ready_chk #(
  .DATA_W(DATA_W), .DEPTH_MAX(DEPTH_MAX), .DEPTH_NORM(DEPTH_NORM), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .dmaMode(dmaMode),
  .txLevelCfg(txLevelCfg), .rxLevelCfg(rxLevelCfg),
  .flowHiCfg(flowHiCfg), .flowLoCfg(flowLoCfg),
  .txPush(txPush), .rxPop(rxPop), .rxPopData(rxPopData),
  .txCount(txCount), .rxCount(rxCount),
  .txReadyN(txReadyN), .rxReadyN(rxReadyN), .txOverrun(txOverrun)
);

// File: tb/chan_fifo_ready_tb.sv
module chan_fifo_ready_tb;
  localparam int DATA_W = 8;
  localparam int DMAX   = 128;
  localparam int DNORM  = 32;
  localparam int CNT_W  = $clog2(DMAX + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaMode = 1'b0;
  logic [7:0] txLevelCfg = '0, rxLevelCfg = '0, flowHiCfg = '0, flowLoCfg = '0;
  logic [CNT_W-1:0] rxTrigLevel = CNT_W'(1);
  logic txPush = 0, txPop = 0, rxPush = 0, rxPop = 0, rxTimeout = 0;
  logic [DATA_W-1:0] txPushData = '0, rxPushData = '0;
  logic [DATA_W-1:0] txPopData, rxPopData;
  logic [CNT_W-1:0] txCount, rxCount;
  logic txReadyN, rxReadyN, txOverrun, rxOverrun;

  always #10 clk = ~clk;

  chan_fifo_ready #(.DATA_W(DATA_W), .DEPTH_MAX(DMAX), .DEPTH_NORM(DNORM)) u_dut (
    .clk(clk), .rstN(rstN), .dmaMode(dmaMode),
    .txLevelCfg(txLevelCfg), .rxLevelCfg(rxLevelCfg),
    .flowHiCfg(flowHiCfg), .flowLoCfg(flowLoCfg), .rxTrigLevel(rxTrigLevel),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop), .txPopData(txPopData),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop), .rxPopData(rxPopData),
    .rxTimeout(rxTimeout), .txCount(txCount), .rxCount(rxCount),
    .txReadyN(txReadyN), .rxReadyN(rxReadyN),
    .txOverrun(txOverrun), .rxOverrun(rxOverrun)
  );

  int compared = 0;
  int mismatched = 0;

  // behavioural reference
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  logic [7:0] mTxLast = 0, mRxLast = 0;
  bit mTxN = 0, mRxN = 1, mTxOvr = 0, mRxOvr = 0;
  bit prevDma = 0;
  string pinTagRx, pinTagTx, capTag;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    int cap;
    bit ext, tw, tr, rw, rr;
    ext = (txLevelCfg != 0) || (rxLevelCfg != 0) || (flowHiCfg != 0) || (flowLoCfg != 0);
    cap = ext ? DMAX : DNORM;
    capTag = ext ? "R4" : "R3";
    tw = txPush && (txQ.size() < cap);
    tr = txPop && (txQ.size() > 0);
    rw = rxPush && (rxQ.size() < cap);
    rr = rxPop && (rxQ.size() > 0);
    mTxOvr = txPush && !tw;
    mRxOvr = rxPush && !rw;
    if (tr) mTxLast = txQ.pop_front();
    if (rr) mRxLast = rxQ.pop_front();
    if (tw) txQ.push_back(txPushData);
    if (rw) rxQ.push_back(rxPushData);
    mTxN = dmaMode ? (txQ.size() >= cap) : (txQ.size() != 0);
    if (!dmaMode) mRxN = (rxQ.size() == 0);
    else if (rxQ.size() == 0) mRxN = 1;
    else if (rxQ.size() >= int'(rxTrigLevel) || rxTimeout) mRxN = 0;
    pinTagTx = dmaMode ? "R8" : "R7";
    pinTagRx = dmaMode ? "R6" : "R5";
    if (dmaMode != prevDma) begin pinTagTx = "R10"; pinTagRx = "R10"; end
    if (rxTimeout && rxQ.size() == 0) pinTagRx = "R11";
    prevDma = dmaMode;
  endtask

  task automatic compareAll();
    chk(capTag, "txCount", int'(txCount), txQ.size());
    chk(capTag, "rxCount", int'(rxCount), rxQ.size());
    chk("R2", "txPopData", int'(txPopData), int'(mTxLast));
    chk("R2", "rxPopData", int'(rxPopData), int'(mRxLast));
    chk(capTag, "txOverrun", int'(txOverrun), int'(mTxOvr));
    chk(capTag, "rxOverrun", int'(rxOverrun), int'(mRxOvr));
    chk(pinTagTx, "txReadyN", int'(txReadyN), int'(mTxN));
    chk(pinTagRx, "rxReadyN", int'(rxReadyN), int'(mRxN));
  endtask

  // one clock: inputs already driven (at negedge), model after edge, compare at negedge
  task automatic step(input bit tp, input bit tpo, input bit rp, input bit rpo, input bit to);
    txPush = tp; txPop = tpo; rxPush = rp; rxPop = rpo; rxTimeout = to;
    txPushData = 8'($urandom); rxPushData = 8'($urandom);
    @(posedge clk);
    #1 modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "txCount", int'(txCount), 0);
    chk("R1", "rxCount", int'(rxCount), 0);
    chk("R1", "rxReadyN", int'(rxReadyN), 1);
    chk("R1", "txReadyN", int'(txReadyN), 0);
    chk("R1", "overrun", int'(txOverrun | rxOverrun), 0);
    chk("R1", "popData", int'(txPopData | rxPopData), 0);
    rstN = 1'b1;
    capTag = "R3"; pinTagTx = "R7"; pinTagRx = "R5";

    // R2, R5, R7: single-transfer mode ordering and level pins
    for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 0);
    step(1, 1, 1, 1, 0);
    for (int i = 0; i < 8; i++) step(0, 1, 0, 1, 0);
    // R9: pops from empty
    step(0, 1, 0, 1, 0);
    step(0, 1, 0, 1, 1);

    // R3: fill to normal capacity and beyond
    for (int i = 0; i < DNORM + 3; i++) step(1, 0, 1, 0, 0);
    // R8, R10: switch to DMA while full
    dmaMode = 1;
    idle(2);
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    // R4: widen capacity with data stored, then fill
    flowLoCfg = 8'h01;
    for (int i = 0; i < DMAX - DNORM + 3; i++) step(1, 0, 1, 0, 0);
    flowLoCfg = 8'h00; rxLevelCfg = 8'h10;
    step(1, 0, 1, 0, 0);
    rxLevelCfg = 8'h00;
    step(1, 0, 1, 0, 0);
    for (int i = 0; i < DMAX + 2; i++) step(0, 1, 0, 1, 0);

    // R6, R11: DMA receive trigger, hold and timeout
    rxTrigLevel = CNT_W'(4);
    step(0, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0);
    rxTrigLevel = CNT_W'(0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0);

    // mixed traffic with mode and configuration changes
    for (int i = 0; i < 4000; i++) begin
      if (i % 97 == 0)  dmaMode = ~dmaMode;
      if (i % 211 == 0) txLevelCfg = (txLevelCfg == 0) ? 8'h05 : 8'h00;
      if (i % 53 == 0)  rxTrigLevel = CNT_W'($urandom_range(0, 40));
      step(($urandom % 4) != 0, ($urandom % 3) == 0,
           ($urandom % 3) != 0, ($urandom % 4) == 0, ($urandom % 16) == 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule